// File: doc/BRIEF.md
# Eight-Channel Priority Bus Arbiter

This block decides which of eight DMA channels owns a shared bus. Each channel presents a request line, a 3-bit priority level and a flag that marks its transfer as an uninterruptible fill run. The bus side returns a done strobe when the current beat or burst has finished. The arbiter picks the requesting channel with the highest priority level. When several requesters share that level, the lowest channel number wins. The choice is registered and presented as a one-hot grant vector, a binary channel index and a valid flag.

A grant is never taken away in the middle of a transfer. The arbiter re-evaluates only while the bus is idle or in the cycle the done strobe is high. A channel that was granted with its fill flag set keeps the bus across done strobes for as long as it keeps requesting, so no other channel can cut into a memory-fill run. A freeze input stops new grants from being issued. It does not cut short a transfer that is already running, and it does not cut short a fill run.

Top module: `prio_bus_arbiter`

## Requirements
- R1: After reset, `gnt` is all zeros, `gnt_valid` is low and `gnt_idx` is 0.
- R2: Channel i's priority occupies bits [3i+2:3i] of `prio`. Level 7 is the highest and 0 the lowest. At an arbitration point, the requesting channel with the highest level is granted.
- R3: Among requesters that share the highest requested level, the lowest channel index is granted.
- R4: Arbitration happens only in a cycle where no grant is active or `xfer_done` is high. The result appears on the outputs one clock edge later.
- R5: While a grant is active and `xfer_done` is low, the grant and its index do not change, whatever happens on `req`, `prio`, `fill_run` or `freeze`.
- R6: When `xfer_done` is high for a channel granted without the fill flag, arbitration runs over the current requests. The same channel may be granted again.
- R7: A channel whose `fill_run` bit was high when it was granted keeps the grant at every `xfer_done` while its `req` bit stays high, even against higher-priority requesters. At an `xfer_done` with its `req` low, it is released and arbitration runs.
- R8: While `freeze` is high, no new grant is issued at an arbitration point. The bus goes idle instead. An active grant still runs to its `xfer_done`, and a fill run continues.
- R9: At an arbitration point with no request, or with `freeze` high, the outputs become idle: `gnt` is zero, `gnt_valid` is low and `gnt_idx` is 0.
- R10: `gnt` has exactly bit `gnt_idx` set while `gnt_valid` is high, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 8 | Per-channel bus request |
| prio | input | 24 | Per-channel 3-bit priority, channel i at [3i+2:3i] |
| fill_run | input | 8 | Per-channel flag: the transfer is an indivisible fill run |
| xfer_done | input | 1 | Current beat or burst has completed |
| freeze | input | 1 | Blocks new grants while high |
| gnt | output | 8 | One-hot grant |
| gnt_idx | output | 3 | Index of the granted channel |
| gnt_valid | output | 1 | A grant is active |

## Verification
A corrupted owner register shows up at the ports in the very next cycle. Either `gnt` disagrees with the bench's reference, or the grant moves while `xfer_done` is low, which breaks the no-preemption rule. A lost fill lock is subtler. It becomes visible only at the next `xfer_done` that arrives while a higher-priority channel is waiting, when the grant jumps one cycle later. For that reason, directed sequences place a stronger requester next to a running fill channel. Random stimulus with frequent done strobes and freezes then exercises every arbitration point against a bench model that is updated each cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_phase_e;
endpackage

// File: rtl/arb_pick.sv
module arb_pick #(
    parameter int N_CH   = 8,
    parameter int PRIO_W = 3,
    localparam int IDX_W = $clog2(N_CH)
) (
    input  logic [N_CH-1:0]        req,
    input  logic [N_CH*PRIO_W-1:0] prio,
    output logic [IDX_W-1:0]       win_idx,
    output logic                   win_any
);
    logic [PRIO_W-1:0] best_lvl;

    // Scan from channel 0 upward; a strict "greater" keeps the lower index on ties.
    always_comb begin
        win_idx  = '0;
        win_any  = 1'b0;
        best_lvl = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (req[i] && (!win_any || prio[i*PRIO_W +: PRIO_W] > best_lvl)) begin
                win_any  = 1'b1;
                best_lvl = prio[i*PRIO_W +: PRIO_W];
                win_idx  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/arb_decode.sv
module arb_decode #(
    parameter int N_CH = 8,
    localparam int IDX_W = $clog2(N_CH)
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             en,
    output logic [N_CH-1:0]  onehot
);
    for (genvar g = 0; g < N_CH; g++) begin : g_bit
        assign onehot[g] = en && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
    import arb_pkg::*;
#(
    parameter int N_CH   = 8,
    parameter int PRIO_W = 3,
    localparam int IDX_W = $clog2(N_CH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CH-1:0]        req,
    input  logic [N_CH*PRIO_W-1:0] prio,
    input  logic [N_CH-1:0]        fill_run,
    input  logic                   xfer_done,
    input  logic                   freeze,
    output logic [N_CH-1:0]        gnt,
    output logic [IDX_W-1:0]       gnt_idx,
    output logic                   gnt_valid
);
    typedef struct packed {
        arb_phase_e       phase;
        logic             locked;
        logic [IDX_W-1:0] idx;
    } arb_state_t;

    arb_state_t st_d, st_q;
    logic [IDX_W-1:0] win_idx;
    logic             win_any;
    logic             arb_point;
    logic             keep_run;

    arb_pick #(.N_CH(N_CH), .PRIO_W(PRIO_W)) u_pick (
        .req     (req),
        .prio    (prio),
        .win_idx (win_idx),
        .win_any (win_any)
    );

    always_comb begin
        st_d      = st_q;
        arb_point = (st_q.phase == ARB_IDLE) || xfer_done;
        keep_run  = (st_q.phase == ARB_BUSY) && xfer_done && st_q.locked && req[st_q.idx];
        if (arb_point && !keep_run) begin
            if (!freeze && win_any) begin
                st_d.phase  = ARB_BUSY;
                st_d.locked = fill_run[win_idx];
                st_d.idx    = win_idx;
            end else begin
                st_d.phase  = ARB_IDLE;
                st_d.locked = 1'b0;
                st_d.idx    = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: ARB_IDLE, locked: 1'b0, idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_valid = (st_q.phase == ARB_BUSY);
    assign gnt_idx   = st_q.idx;

    arb_decode #(.N_CH(N_CH)) u_dec (
        .idx    (st_q.idx),
        .en     (gnt_valid),
        .onehot (gnt)
    );

    // Grant held between done strobes (no preemption)
    assert_no_preempt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !xfer_done) |=> (gnt_valid && $stable(gnt_idx)));

    // Fill run survives a done strobe while still requesting
    assert_fill_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && st_q.locked && xfer_done && req[gnt_idx]) |=> (gnt_valid && $stable(gnt_idx)));

    // Freeze in idle blocks new grants
    assert_freeze_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_valid && freeze) |=> !gnt_valid);

    // Idle with no requests stays idle
    assert_no_req_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_valid && (req == '0)) |=> !gnt_valid);

    // Idle with a request and no freeze produces a grant next cycle
    assert_grant_issued_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_valid && !freeze && (req != '0)) |=> gnt_valid);

    // Grant vector shape
    assert_gnt_shape_R10: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid ? ($countones(gnt) == 1 && gnt[gnt_idx]) : (gnt == '0));
endmodule

// File: tb/prio_bus_arbiter_test.sv
`timescale 1ns/1ps
module prio_bus_arbiter_test;
    localparam int N = 8;
    localparam int PW = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   req = '0;
    logic [23:0]  prio = '0;
    logic [7:0]   fill_run = '0;
    logic         xfer_done = 1'b0;
    logic         freeze = 1'b0;
    logic [7:0]   gnt;
    logic [2:0]   gnt_idx;
    logic         gnt_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    // bench reference state
    logic       m_valid = 1'b0;
    logic       m_lock = 1'b0;
    logic [2:0] m_idx = '0;
    string      pend_tag = "R1";

    prio_bus_arbiter #(.N_CH(N), .PRIO_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .prio(prio), .fill_run(fill_run),
        .xfer_done(xfer_done), .freeze(freeze),
        .gnt(gnt), .gnt_idx(gnt_idx), .gnt_valid(gnt_valid)
    );

    always #2 clk = ~clk;

    function automatic logic [23:0] pset(input logic [23:0] base, input int ch, input int lvl);
        logic [23:0] r = base;
        r[ch*3 +: 3] = 3'(lvl);
        return r;
    endfunction

    // highest level, lowest index on ties
    function automatic int best(input logic [7:0] r, input logic [23:0] p);
        int b = -1;
        for (int i = 0; i < N; i++)
            if (r[i] && (b < 0 || p[i*3 +: 3] > p[b*3 +: 3])) b = i;
        return b;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        logic [7:0] eg = m_valid ? (8'b1 << m_idx) : 8'b0;
        chk({tag, " valid"}, int'(gnt_valid), int'(m_valid));
        chk({tag, " index"}, int'(gnt_idx), int'(m_idx));
        chk({"R10 gnt vector (", tag, ")"}, int'(gnt), int'(eg));
    endtask

    task automatic model_next();
        bit arb = !m_valid || xfer_done;
        bit keep = m_valid && xfer_done && m_lock && req[m_idx];
        int w;
        if (arb && !keep) begin
            w = best(req, prio);
            if (!freeze && w >= 0) begin
                m_valid = 1'b1; m_idx = 3'(w); m_lock = fill_run[w];
            end else begin
                m_valid = 1'b0; m_idx = '0; m_lock = 1'b0;
            end
        end
    endtask

    task automatic step(input logic [7:0] r, input logic [23:0] p, input logic [7:0] f,
                        input logic d, input logic z, input string tag);
        @(negedge clk);
        compare(pend_tag);
        req = r; prio = p; fill_run = f; xfer_done = d; freeze = z;
        model_next();
        pend_tag = tag;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [23:0] p;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        pend_tag = "R1 after release";

        // R2: level 5 beats level 2
        p = pset(pset('0, 1, 2), 2, 5);
        step(8'b0000_0110, p, '0, 1'b0, 1'b0, "R2 highest level wins");
        // R5: no done, stronger requester appears
        p = pset(p, 7, 7);
        step(8'b1000_0110, p, '0, 1'b0, 1'b0, "R5 held without done");
        step(8'b1000_0000, p, 8'hFF, 1'b0, 1'b1, "R5 held under freeze");
        // R3 / R6: done, ch3 and ch5 both at level 4
        p = pset(pset('0, 3, 4), 5, 4);
        step(8'b0010_1000, p, '0, 1'b1, 1'b0, "R3 tie goes to lower index");
        step(8'b0010_1000, p, '0, 1'b1, 1'b0, "R6 regrant same channel");
        // R7: fill channel 6 at level 0
        p = pset('0, 0, 7);
        step(8'b0100_0000, p, 8'b0100_0000, 1'b1, 1'b0, "R7 fill channel granted");
        step(8'b0100_0001, p, 8'b0100_0000, 1'b1, 1'b0, "R7 fill kept against level 7");
        step(8'b0100_0001, p, 8'b0000_0000, 1'b1, 1'b1, "R7 fill kept under freeze R8");
        step(8'b0000_0001, p, 8'b0000_0000, 1'b1, 1'b0, "R7 fill released");
        // R8: freeze at done of normal channel
        step(8'b0000_0010, p, '0, 1'b1, 1'b1, "R8 freeze idles bus");
        step(8'b0000_0010, p, '0, 1'b0, 1'b1, "R8 frozen idle stays idle");
        // R9: no requests
        step(8'b0000_0000, p, '0, 1'b0, 1'b0, "R9 no request idle");
        step(8'b0000_0100, p, '0, 1'b0, 1'b0, "R4 grant after one edge");
        step(8'b0000_0000, p, '0, 1'b1, 1'b0, "R9 done with no request");

        // constrained random
        for (int k = 0; k < 4000; k++) begin
            logic [7:0] r  = 8'($urandom);
            logic [7:0] f  = 8'($urandom) & 8'($urandom);
            logic       d  = ($urandom % 3) == 0;
            logic       z  = ($urandom % 8) == 0;
            logic [23:0] rp = 24'($urandom);
            if (($urandom % 4) == 0) rp = {8{3'd3}};
            step(r, rp, f, d, z, "R4 random");
        end
        step('0, '0, '0, 1'b1, 1'b0, "R9 final drain");
        @(negedge clk);
        compare(pend_tag);

        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule